// File: doc/BRIEF.md
# Multichannel PCM Serial Output Interface

This block puts six channels of 32-bit two's-complement PCM onto three serial data lines that share one bit clock and one word clock. Line 0 carries front left and front right. Line 1 carries surround left and surround right. Line 2 carries center and subwoofer. A new set of six samples is taken from parallel input ports at each word-boundary edge. The framing is either MSB-first left-justified or I2S. In both cases a slot holds 32 bits and the data changes on the falling bit-clock edge.

As clock master, the block divides its 512fs master clock to produce a bit clock and a word clock at a word rate of fs, 2fs or 4fs. As clock slave, it follows a bit clock and word clock supplied from outside. These must be synchronous to the master clock, and each bit-clock level must last at least two master-clock cycles. An active-low mute forces the data lines to zero at the output. A bypass select routes an external data triplet, bit clock and word clock straight to the pins. In bypass the clock pins are driven regardless of the master/slave setting.

Top module: `pcm_serial_out`

## Requirements
- R1: In master mode the word-clock period is 128, 256 or 512 `clk` cycles. `rate_sel[1]`=1 selects fs (512) and takes priority over `rate_sel[0]`. Otherwise `rate_sel[0]`=1 selects 4fs (128) and `rate_sel[0]`=0 selects 2fs (256).
- R2: In master mode there are exactly 32 bit-clock periods in each word-clock half. At 4fs the bit clock toggles on every `clk` edge. The word clock changes only together with a falling bit-clock edge.
- R3: With `fmt_i2s`=0 (left-justified), `wck_out` high marks the left slot. The MSB of a slot appears at the first bit-clock fall of that half. Data changes only on falling bit-clock edges, so a receiver samples it on rising edges.
- R4: With `fmt_i2s`=1 (I2S), `wck_out` low marks the left slot. The MSB appears one bit clock after the word-clock edge, and the LSB of a slot falls into the first bit period of the following half.
- R5: `data_out[0]` carries `smp_fl` in the left slot and `smp_fr` in the right slot. `data_out[1]` carries `smp_sl` and `smp_sr`. `data_out[2]` carries `smp_c` and `smp_sw`.
- R6: All six sample ports are latched at the word-boundary edge, which is the start of the left slot. Input changes made after that edge appear in the following frame.
- R7: With `clk_slave`=1 the block follows `bck_in` and `wck_in`. In left-justified slave mode, every bit after the 32nd in a half period is driven as 0.
- R8: While `mute_n` is low and bypass is off, all `data_out` lines are 0 at once, with no clock delay.
- R9: With `ext_sel`=1, `data_out`, `bck_out` and `wck_out` equal `ext_data`, `ext_bck` and `ext_wck`, and `clk_oe` is 1. This holds whatever the values of `clk_slave` and `mute_n`.
- R10: While `rst_n` is low (master mode, no bypass), `data_out` is 0 and `bck_out` is 1. `wck_out` is 0 for left-justified and 1 for I2S.
- R11: With bypass off, `clk_oe` is 1 in master mode and 0 in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 512fs master clock |
| rst_n | input | 1 | synchronous active-low reset |
| rate_sel | input | 2 | word-rate select ([1] fs priority, [0] 4fs else 2fs) |
| fmt_i2s | input | 1 | 0 left-justified, 1 I2S |
| clk_slave | input | 1 | 1 follow external bit/word clock |
| mute_n | input | 1 | active-low data mute |
| ext_sel | input | 1 | 1 selects external bypass path |
| smp_fl | input | 32 | front left sample |
| smp_fr | input | 32 | front right sample |
| smp_sl | input | 32 | surround left sample |
| smp_sr | input | 32 | surround right sample |
| smp_c | input | 32 | center sample |
| smp_sw | input | 32 | subwoofer sample |
| bck_in | input | 1 | bit clock received in slave mode |
| wck_in | input | 1 | word clock received in slave mode |
| ext_bck | input | 1 | bypass bit clock |
| ext_wck | input | 1 | bypass word clock |
| ext_data | input | 3 | bypass data lines |
| bck_out | output | 1 | bit clock driven to pin |
| wck_out | output | 1 | word clock driven to pin |
| clk_oe | output | 1 | 1 when the clock pins are driven |
| data_out | output | 3 | serial data lines |

## Verification
A wrong slot tracker or a wrong shift register shows up as a mis-decoded word within the frame in which it goes wrong. Either the channel order on a line is swapped, or a word is shifted by one bit between the two formats. A wrong divider shows up as a changed word period or a count other than 32 rising edges per half, measured between two consecutive word boundaries. A sample latched at the wrong moment mixes values from two consecutive frames in one decoded frame. Mute and bypass faults appear on the pins in the same cycle as the select change.

// File: rtl/pcm_out_pkg.sv
// Shared definitions for the multichannel PCM serial output interface.
// Assumes one 512fs master clock; all other timing is derived from it.
package pcm_out_pkg;

    localparam int SLOT_BITS_DEF     = 32;
    localparam int LINES             = 3;
    localparam int MCLK_PER_WORD_DEF = 512;

    // Word-rate selection after priority resolution; value = divider shift.
    typedef enum logic [1:0] {
        RATE_1X = 2'd0,
        RATE_2X = 2'd1,
        RATE_4X = 2'd2
    } rate_e;

    // Resolve the two select bits: full rate wins, then quadruple, else double.
    function automatic rate_e decode_rate(input logic [1:0] sel);
        if (sel[1])
            return RATE_1X;
        else if (sel[0])
            return RATE_4X;
        else
            return RATE_2X;
    endfunction

endpackage

// File: rtl/pcm_master_clk.sv
// Master-mode clock generator.
// Divides the master clock into a bit clock and a word clock for the chosen
// word rate, and flags the cycle on which the bit clock is about to fall.
// Assumes MCLK_PER_WORD / (2*SLOT_BITS) >= 8 so the 4x rate still has a
// bit period of at least two master clocks.
module pcm_master_clk
    import pcm_out_pkg::*;
#(
    parameter int SLOT_BITS     = SLOT_BITS_DEF,
    parameter int MCLK_PER_WORD = MCLK_PER_WORD_DEF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  rate_e rate,
    input  logic  fmt_i2s,
    output logic  m_bck,
    output logic  m_wck,
    output logic  m_fall,
    output logic  m_wck_next
);

    localparam int CNT_W  = $clog2(MCLK_PER_WORD);
    localparam int BIT_SH = CNT_W - 1 - $clog2(SLOT_BITS);  // log2 bit period at 1x
    localparam int B1 = BIT_SH - 1;                         // bck bit at 1x
    localparam int B2 = BIT_SH - 2;                         // bck bit at 2x
    localparam int B4 = BIT_SH - 3;                         // bck bit at 4x

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             right_now;
    logic             right_nxt;

    // Position counter; all-ones at reset puts both clocks in their idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else
            cnt <= cnt_nxt;
    end

    // Decode bit clock, slot half and the pre-fall flag for the active rate.
    always_comb begin
        unique case (rate)
            RATE_4X: begin
                cnt_nxt   = (cnt + 1'b1) & ({CNT_W{1'b1}} >> 2);
                m_bck     = cnt[B4];
                m_fall    = &cnt[B4:0];
                right_now = cnt[CNT_W-3];
                right_nxt = cnt_nxt[CNT_W-3];
            end
            RATE_2X: begin
                cnt_nxt   = (cnt + 1'b1) & ({CNT_W{1'b1}} >> 1);
                m_bck     = cnt[B2];
                m_fall    = &cnt[B2:0];
                right_now = cnt[CNT_W-2];
                right_nxt = cnt_nxt[CNT_W-2];
            end
            default: begin
                cnt_nxt   = cnt + 1'b1;
                m_bck     = cnt[B1];
                m_fall    = &cnt[B1:0];
                right_now = cnt[CNT_W-1];
                right_nxt = cnt_nxt[CNT_W-1];
            end
        endcase
    end

    // Word clock polarity: left half is high for left-justified, low for I2S.
    assign m_wck      = fmt_i2s ? right_now : ~right_now;
    assign m_wck_next = fmt_i2s ? right_nxt : ~right_nxt;

endmodule

// File: rtl/pcm_slave_edge.sv
// Slave-mode edge detector.
// Samples the received bit clock and reports a falling edge on the master
// clock edge that first sees it low, together with the current word clock.
// Assumes the received clocks are synchronous to clk.
module pcm_slave_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bck_in,
    input  logic wck_in,
    output logic s_fall,
    output logic s_wck
);

    logic bck_q;

    // Previous bit-clock level for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bck_q <= 1'b0;
        else
            bck_q <= bck_in;
    end

    assign s_fall = bck_q & ~bck_in;
    assign s_wck  = wck_in;

endmodule

// File: rtl/pcm_lane_ser.sv
// One serial data line.
// Holds the pair of words for one line, shifts them out MSB first on each
// bit-clock fall, and fills with zeros once a word is exhausted. The I2S
// stream is the left-justified stream delayed by one bit period.
// Assumes fall_evt pulses for one clk per bit-clock fall.
module pcm_lane_ser #(
    parameter int SLOT_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fmt_i2s,
    input  logic                 fall_evt,
    input  logic                 boundary,
    input  logic                 to_right,
    input  logic [SLOT_BITS-1:0] left_word,
    input  logic [SLOT_BITS-1:0] right_word,
    output logic                 ser_bit
);

    localparam int MSB = SLOT_BITS - 1;

    logic [SLOT_BITS-1:0] shreg;
    logic [SLOT_BITS-1:0] hold_right;
    logic                 lj_bit;
    logic                 dly_bit;

    // Load on slot start, otherwise shift; zeros enter from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            hold_right <= '0;
            lj_bit     <= 1'b0;
            dly_bit    <= 1'b0;
        end else if (fall_evt) begin
            dly_bit <= lj_bit;
            if (boundary) begin
                lj_bit     <= left_word[MSB];
                shreg      <= left_word << 1;
                hold_right <= right_word;
            end else if (to_right) begin
                lj_bit <= hold_right[MSB];
                shreg  <= hold_right << 1;
            end else begin
                lj_bit <= shreg[MSB];
                shreg  <= shreg << 1;
            end
        end
    end

    assign ser_bit = fmt_i2s ? dly_bit : lj_bit;

endmodule

// File: rtl/pcm_serial_out.sv
// Multichannel PCM serial output interface (top).
// Serializes six 32-bit samples onto three lines in left-justified or I2S
// framing, as clock master or slave, with mute and an external bypass.
// Assumes slave clocks are synchronous to clk with levels >= 2 clk long.
module pcm_serial_out
    import pcm_out_pkg::*;
#(
    parameter int SLOT_BITS     = SLOT_BITS_DEF,
    parameter int MCLK_PER_WORD = MCLK_PER_WORD_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           rate_sel,
    input  logic                 fmt_i2s,
    input  logic                 clk_slave,
    input  logic                 mute_n,
    input  logic                 ext_sel,
    input  logic [SLOT_BITS-1:0] smp_fl,
    input  logic [SLOT_BITS-1:0] smp_fr,
    input  logic [SLOT_BITS-1:0] smp_sl,
    input  logic [SLOT_BITS-1:0] smp_sr,
    input  logic [SLOT_BITS-1:0] smp_c,
    input  logic [SLOT_BITS-1:0] smp_sw,
    input  logic                 bck_in,
    input  logic                 wck_in,
    input  logic                 ext_bck,
    input  logic                 ext_wck,
    input  logic [LINES-1:0]     ext_data,
    output logic                 bck_out,
    output logic                 wck_out,
    output logic                 clk_oe,
    output logic [LINES-1:0]     data_out
);

    rate_e                rate;
    logic                 m_bck, m_wck, m_fall, m_wck_next;
    logic                 s_fall, s_wck;
    logic                 fall_evt, wck_next, left_next;
    logic                 last_left;
    logic                 slot_chg, boundary, to_right;
    logic [SLOT_BITS-1:0] left_w  [LINES];
    logic [SLOT_BITS-1:0] right_w [LINES];
    logic [LINES-1:0]     ser;

    assign rate = decode_rate(rate_sel);

    pcm_master_clk #(
        .SLOT_BITS     (SLOT_BITS),
        .MCLK_PER_WORD (MCLK_PER_WORD)
    ) mclk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate       (rate),
        .fmt_i2s    (fmt_i2s),
        .m_bck      (m_bck),
        .m_wck      (m_wck),
        .m_fall     (m_fall),
        .m_wck_next (m_wck_next)
    );

    pcm_slave_edge sedge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .bck_in (bck_in),
        .wck_in (wck_in),
        .s_fall (s_fall),
        .s_wck  (s_wck)
    );

    // Pick the event source: generated clocks as master, received as slave.
    assign fall_evt  = clk_slave ? s_fall : m_fall;
    assign wck_next  = clk_slave ? s_wck  : m_wck_next;
    assign left_next = fmt_i2s ? ~wck_next : wck_next;
    assign slot_chg  = fall_evt & (left_next != last_left);
    assign boundary  = slot_chg & left_next;
    assign to_right  = slot_chg & ~left_next;

    // Slot seen at the last bit-clock fall; starts on the right slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_left <= 1'b0;
        else if (fall_evt)
            last_left <= left_next;
    end

    assign left_w[0]  = smp_fl;
    assign right_w[0] = smp_fr;
    assign left_w[1]  = smp_sl;
    assign right_w[1] = smp_sr;
    assign left_w[2]  = smp_c;
    assign right_w[2] = smp_sw;

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        pcm_lane_ser #(
            .SLOT_BITS (SLOT_BITS)
        ) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .fmt_i2s    (fmt_i2s),
            .fall_evt   (fall_evt),
            .boundary   (boundary),
            .to_right   (to_right),
            .left_word  (left_w[g]),
            .right_word (right_w[g]),
            .ser_bit    (ser[g])
        );
    end

    // Pin multiplexing: bypass first, then mute applied right at the output.
    always_comb begin
        if (ext_sel) begin
            bck_out  = ext_bck;
            wck_out  = ext_wck;
            clk_oe   = 1'b1;
            data_out = ext_data;
        end else begin
            bck_out  = m_bck;
            wck_out  = m_wck;
            clk_oe   = ~clk_slave;
            data_out = mute_n ? ser : '0;
        end
    end

endmodule

// File: rtl/pcm_serial_out_chk.sv
// Port-level checker for pcm_serial_out, attached with bind.
module pcm_serial_out_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rate_sel,
    input logic       fmt_i2s,
    input logic       clk_slave,
    input logic       mute_n,
    input logic       ext_sel,
    input logic       ext_bck,
    input logic       ext_wck,
    input logic [2:0] ext_data,
    input logic       bck_out,
    input logic       wck_out,
    input logic       clk_oe,
    input logic [2:0] data_out
);

    // R3: in a steady master setup, data moves only with a bit-clock fall.
    a_r3_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_slave && !ext_sel && $past(rst_n) && $stable(rate_sel) &&
         $stable(fmt_i2s) && $stable(mute_n) && $stable(clk_slave) &&
         $stable(ext_sel) && (data_out != $past(data_out))) |-> $fell(bck_out));

    // R2: in a steady master setup, the word clock moves only with a fall.
    a_r2_wck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_slave && !ext_sel && $past(rst_n) && $stable(rate_sel) &&
         $stable(fmt_i2s) && $stable(clk_slave) && $stable(ext_sel) &&
         (wck_out != $past(wck_out))) |-> $fell(bck_out));

    // R2: at the 4x rate the generated bit clock toggles every cycle.
    a_r2_quad_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_slave && !ext_sel && rate_sel == 2'b01 && $past(rst_n) &&
         $stable(rate_sel) && $stable(ext_sel)) |-> (bck_out != $past(bck_out)));

    // R8: muted lines are zero.
    a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_n && !ext_sel) |-> (data_out == 3'b000));

    // R9: bypass forwards every external signal and drives the clocks.
    a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |-> (bck_out == ext_bck && wck_out == ext_wck &&
                     data_out == ext_data && clk_oe));

    // R11: clock pin direction follows the master/slave select.
    a_r11_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_sel |-> (clk_oe == !clk_slave));

endmodule

bind pcm_serial_out pcm_serial_out_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_sel  (rate_sel),
    .fmt_i2s   (fmt_i2s),
    .clk_slave (clk_slave),
    .mute_n    (mute_n),
    .ext_sel   (ext_sel),
    .ext_bck   (ext_bck),
    .ext_wck   (ext_wck),
    .ext_data  (ext_data),
    .bck_out   (bck_out),
    .wck_out   (wck_out),
    .clk_oe    (clk_oe),
    .data_out  (data_out)
);

// File: tb/pcm_serial_out_tb_top.sv
// Scoreboard bench: the driver pushes expected frames, the monitor decodes
// the serial lines on rising bit-clock edges and compares.
module pcm_serial_out_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'b01;
    logic        fmt_i2s = 1'b0;
    logic        clk_slave = 1'b0;
    logic        mute_n = 1'b1;
    logic        ext_sel = 1'b0;
    logic [31:0] smp [6];
    logic        tb_bck = 1'b1;
    logic        tb_wck = 1'b0;
    logic        ext_bck = 1'b0;
    logic        ext_wck = 1'b0;
    logic [2:0]  ext_data = 3'b000;
    logic        bck_out, wck_out, clk_oe;
    logic [2:0]  data_out;
    logic        line_bck, line_wck;

    always #4 clk = ~clk;

    pcm_serial_out dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .fmt_i2s   (fmt_i2s),
        .clk_slave (clk_slave),
        .mute_n    (mute_n),
        .ext_sel   (ext_sel),
        .smp_fl    (smp[0]),
        .smp_fr    (smp[1]),
        .smp_sl    (smp[2]),
        .smp_sr    (smp[3]),
        .smp_c     (smp[4]),
        .smp_sw    (smp[5]),
        .bck_in    (tb_bck),
        .wck_in    (tb_wck),
        .ext_bck   (ext_bck),
        .ext_wck   (ext_wck),
        .ext_data  (ext_data),
        .bck_out   (bck_out),
        .wck_out   (wck_out),
        .clk_oe    (clk_oe),
        .data_out  (data_out)
    );

    assign line_bck = clk_oe ? bck_out : tb_bck;
    assign line_wck = clk_oe ? wck_out : tb_wck;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    typedef struct packed {
        int             id;
        logic [5:0][31:0] w;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    int          cyc = 0;
    always @(posedge clk) cyc++;

    bit          mon_en = 0;
    bit          mon_seen, mon_active, prev_left, nz_seen;
    logic [2:0][31:0] acc, left_acc;
    int          bit_cnt, slot_rises, frame_id, period, last_start;
    event        ev_start;

    task automatic mon_clear();
        mon_seen = 0; mon_active = 0; prev_left = 0; nz_seen = 0;
        acc = '0; left_acc = '0; bit_cnt = 0; slot_rises = 0;
        frame_id = 0; period = 0; last_start = 0;
        exp_q.delete(); tag_q.delete();
    endtask

    task automatic add_bits(input logic [2:0] b);
        for (int i = 0; i < 3; i++)
            if (bit_cnt < 32) acc[i] = {acc[i][30:0], b[i]};
            else if (b[i]) nz_seen = 1;
        bit_cnt++;
    endtask

    task automatic finish_slot(input bit was_left);
        slot_rises = bit_cnt;
        if (was_left) begin
            left_acc = acc;
        end else begin
            while (exp_q.size() > 0 && exp_q[0].id < frame_id) begin
                chk(0, "R6", "expected frame never seen", frame_id, exp_q[0].id);
                void'(exp_q.pop_front()); void'(tag_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0].id == frame_id) begin
                exp_t e; string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                for (int i = 0; i < 3; i++) begin
                    chk(left_acc[i] == e.w[2*i], t, $sformatf("R5 line%0d left", i),
                        left_acc[i], e.w[2*i]);
                    chk(acc[i] == e.w[2*i+1], t, $sformatf("R5 line%0d right", i),
                        acc[i], e.w[2*i+1]);
                end
            end
        end
    endtask

    // Monitor: decode on rising bit clock, frame starts at left slot start.
    always @(posedge line_bck) begin
        if (mon_en) begin
            logic lft;
            lft = fmt_i2s ? ~line_wck : line_wck;
            if (!mon_seen) begin
                mon_seen = 1; prev_left = lft;
            end else if (lft != prev_left) begin
                if (fmt_i2s) add_bits(data_out);
                if (mon_active) finish_slot(prev_left);
                mon_active = 1; acc = '0; bit_cnt = 0;
                if (lft) begin
                    frame_id++;
                    period = cyc - last_start;
                    last_start = cyc;
                    -> ev_start;
                end
                if (!fmt_i2s) add_bits(data_out);
                prev_left = lft;
            end else begin
                add_bits(data_out);
            end
        end
    end

    function automatic logic [31:0] pat(input int k, input int i);
        if (k == 0) begin
            case (i)
                0: return 32'h8000_0001;
                1: return 32'h7FFF_FFFF;
                2: return 32'hFFFF_FFFF;
                3: return 32'h0000_0001;
                4: return 32'hA5A5_5A5A;
                default: return 32'h0123_4567;
            endcase
        end
        return (32'h9E37_79B9 * (k * 6 + i + 1)) ^ (32'(i) << 27);
    endfunction

    // Driver: after each frame start, present the next frame and push it.
    task automatic drive_frames(input int n, input int base, input string tag);
        for (int f = 0; f < n; f++) begin
            exp_t e;
            @(ev_start);
            for (int i = 0; i < 6; i++) begin
                smp[i] = pat(base + f, i);
                e.w[i] = pat(base + f, i);
            end
            e.id = frame_id + 1;
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        @(ev_start);
        @(ev_start);
        chk(exp_q.size() == 0, "R6", "frames left uncompared", exp_q.size(), 0);
    endtask

    // Slave clock source: bits per half, h clk cycles per level.
    task automatic slave_gen(input int frames, input int bits, input int h);
        for (int fr = 0; fr < frames; fr++)
            for (int half = 0; half < 2; half++)
                for (int b = 0; b < bits; b++) begin
                    @(negedge clk);
                    tb_bck = 1'b0;
                    if (b == 0) tb_wck = fmt_i2s ? (half == 1) : (half == 0);
                    repeat (h) @(negedge clk);
                    tb_bck = 1'b1;
                    repeat (h - 1) @(negedge clk);
                end
    endtask

    task automatic reset_dut(input logic [1:0] rs, input logic fmt,
                             input logic slv, input string tag);
        @(negedge clk);
        rst_n = 0; mon_en = 0; mon_clear();
        rate_sel = rs; fmt_i2s = fmt; clk_slave = slv; ext_sel = 0; mute_n = 1;
        tb_bck = 1'b1; tb_wck = fmt;
        for (int i = 0; i < 6; i++) smp[i] = '0;
        repeat (4) @(negedge clk);
        if (!slv) begin
            chk(data_out == 3'b000, "R10", {tag, " reset data"}, data_out, 0);
            chk(bck_out == 1'b1, "R10", {tag, " reset bck"}, bck_out, 1);
            chk(wck_out == fmt, "R10", {tag, " reset wck"}, wck_out, fmt);
        end
        chk(clk_oe == !slv, "R11", {tag, " clock direction"}, clk_oe, !slv);
        rst_n = 1; mon_en = 1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) smp[i] = '0;
        mon_clear();

        // Master, left-justified, 4x rate (R1 R2 R3 R5 R6 R10 R11).
        reset_dut(2'b01, 1'b0, 1'b0, "lj4x");
        drive_frames(4, 0, "R3");
        chk(period == 128, "R1", "4x word period", period, 128);
        chk(slot_rises == 32, "R2", "4x bits per half", slot_rises, 32);

        // Master, left-justified, 2x rate.
        reset_dut(2'b00, 1'b0, 1'b0, "lj2x");
        drive_frames(3, 10, "R6");
        chk(period == 256, "R1", "2x word period", period, 256);
        chk(slot_rises == 32, "R2", "2x bits per half", slot_rises, 32);

        // Master, I2S, full rate chosen by priority bit (R1 R4 R10).
        reset_dut(2'b11, 1'b1, 1'b0, "i2s1x");
        drive_frames(3, 20, "R4");
        chk(period == 512, "R1", "1x word period (priority)", period, 512);
        chk(slot_rises == 32, "R2", "1x bits per half", slot_rises, 32);

        // Slave, left-justified, 40 bit clocks per half (R7 R11).
        reset_dut(2'b01, 1'b0, 1'b1, "slvlj");
        fork
            slave_gen(7, 40, 2);
            drive_frames(3, 30, "R7");
        join
        chk(slot_rises == 40, "R7", "slave bits per half", slot_rises, 40);
        chk(nz_seen == 0, "R7", "zero fill after bit 32", nz_seen, 0);

        // Slave, I2S, 32 bit clocks per half.
        reset_dut(2'b01, 1'b1, 1'b1, "slvi2s");
        fork
            slave_gen(7, 32, 3);
            drive_frames(3, 40, "R7");
        join

        // Mute in master 4x with nonzero samples (R8).
        reset_dut(2'b01, 1'b0, 1'b0, "mute");
        for (int i = 0; i < 6; i++) smp[i] = 32'hFFFF_FFFF;
        repeat (300) @(negedge clk);
        chk(data_out != 3'b000, "R8", "unmuted data active", data_out, 3'b111);
        mute_n = 0;
        #1;
        chk(data_out == 3'b000, "R8", "mute immediate", data_out, 0);
        begin
            bit bad = 0;
            logic [2:0] seen = 0;
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                if (data_out != 3'b000) begin bad = 1; seen = data_out; end
            end
            chk(!bad, "R8", "mute held", seen, 0);
        end

        // Bypass with slave set and mute on (R9).
        @(negedge clk);
        ext_sel = 1; clk_slave = 1;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            ext_bck = p[0]; ext_wck = p[1]; ext_data = 3'(p * 3 + 2);
            #1;
            chk(data_out == ext_data, "R9", "bypass data", data_out, ext_data);
            chk(bck_out == ext_bck && wck_out == ext_wck, "R9", "bypass clocks",
                {bck_out, wck_out}, {ext_bck, ext_wck});
            chk(clk_oe == 1'b1, "R9", "bypass drives clocks", clk_oe, 1);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule